// File: doc/BRIEF.md
# Display Controller Configuration Register Bank

This block is the software-facing configuration store of a frame-buffer display controller. A processor reaches it through a memory-mapped slave port with word offsets, and it holds the frame buffer base and length, a command word, a status word and eight 16-bit panel timing values. Every register comes out of reset with a value that suits a 240 by 320 panel, so the controller can run before software has written anything.

The command word starts and stops the controller, enables the end-of-frame interrupt and drives three power-enable pins directly. The timing generator reports each frame boundary with two single-cycle pulses. At a frame end a sticky flag is set and, when enabled, the interrupt line is raised. At a frame start the programmed buffer address is copied to the DMA reader. Software therefore services the interrupt, writes the next buffer address and clears the flag, and the new address takes effect on the next frame.

Top module: `dispcfg_regs`

## Requirements
- R1: After reset the registers read back as follows. Offset 0x0 (buffer address) reads 0 and 0x1 (buffer length) reads 76800. 0x2 (command) and 0x3 (status) read 0. The timing registers read 0x4=12, 0x5=18, 0x6=8, 0x7=20, 0x8=240, 0x9=320, 0xA=2 and 0xB=7. The outputs irq, ctl_run, the three power pins and dma_base are all 0.
- R2: A read with chipselect returns its data on s_readdata with s_readdatavalid high in the cycle after the request, and s_readdatavalid is low otherwise. Offsets 0xC to 0xF read 0. Command bits 7:6 always read 0.
- R3: Offsets 0x4 to 0xB are 16 bits wide. A write stores s_writedata[15:0] and ignores the upper bits. The stored value appears on the matching timing output one cycle after the write.
- R4: Command bit 0 (start) is kept as written. It reads back, it drives ctl_run and it appears as status bit 0 (run).
- R5: Command bit 1 (stop) is self-clearing and always reads 0. Writing it as 1 clears the start bit, and stop wins when start is written in the same word.
- R6: Command bits 3, 4 and 5 drive pwr_stepup, pwr_backlight and pwr_panel one cycle after the write.
- R7: A frame_end pulse sets the sticky end-of-frame flag, which reads as status bit 1.
- R8: irq is high exactly while the end-of-frame flag and command bit 2 (IRQ enable) are both set. Writing status with bit 1 set clears the flag. A frame_end in the same cycle as the clear wins, and the flag stays set.
- R9: dma_base takes the value of the buffer address register only on a frame_start pulse. It uses the value held before any write in that same cycle, so a write in mid-frame does not change dma_base until the next frame_start.
- R10: Writes to status bit 0 and to offsets 0xC to 0xF have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_chipselect | input | 1 | Slave select |
| s_read | input | 1 | Read request |
| s_write | input | 1 | Write request |
| s_address | input | 4 | Word offset |
| s_writedata | input | 32 | Write data |
| s_readdata | output | 32 | Read data, one cycle after the request |
| s_readdatavalid | output | 1 | Read data valid |
| frame_start | input | 1 | Single-cycle pulse at the start of a frame |
| frame_end | input | 1 | Single-cycle pulse at the end of a frame |
| irq | output | 1 | End-of-frame interrupt |
| ctl_run | output | 1 | Controller run enable |
| pwr_stepup | output | 1 | Step-up converter enable |
| pwr_backlight | output | 1 | Backlight enable |
| pwr_panel | output | 1 | Panel enable |
| dma_base | output | 32 | Buffer address latched for the current frame |
| dma_len | output | 32 | Buffer length in pixels |
| t_hbp | output | 16 | Horizontal back porch, in dot clocks |
| t_hfp | output | 16 | Horizontal front porch, in dot clocks |
| t_vbp | output | 16 | Vertical back porch, in lines |
| t_vfp | output | 16 | Vertical front porch, in lines |
| t_hdata | output | 16 | Active dot clocks per line |
| t_vdata | output | 16 | Active lines per frame |
| t_hsync | output | 16 | Horizontal sync length, in dot clocks |
| t_vsync | output | 16 | Vertical sync length, in lines |

## Verification
If the end-of-frame flag is set or cleared wrongly, irq is wrong on the first cycle after the frame_end pulse or the clearing write, and the next status read shows the same error. If the shadow address is corrupted, dma_base shows it at once. A missed latch shows up only after the next frame_start, so the bench fires frame_start pulses both with and without a pending write. Bad command decoding shows on ctl_run and on the power pins one cycle after the write. A wrong reset default or a field truncated to the wrong width shows up only when the register is read, so every offset is read back.

// File: rtl/dispcfg_pkg.sv
package dispcfg_pkg;

    localparam int OFS_W   = 4;
    localparam int NUM_TIM = 8;

    localparam logic [OFS_W-1:0] OFS_FBADDR = 4'h0;
    localparam logic [OFS_W-1:0] OFS_FBLEN  = 4'h1;
    localparam logic [OFS_W-1:0] OFS_CMD    = 4'h2;
    localparam logic [OFS_W-1:0] OFS_STAT   = 4'h3;
    localparam logic [OFS_W-1:0] OFS_TIM0   = 4'h4;
    localparam logic [OFS_W-1:0] OFS_TIMEND = 4'hC;

    localparam int CMD_START  = 0;
    localparam int CMD_STOP   = 1;
    localparam int CMD_IRQEN  = 2;
    localparam int CMD_STEPUP = 3;
    localparam int CMD_BLIGHT = 4;
    localparam int CMD_PANEL  = 5;
    localparam int CMD_W      = 6;

    localparam int STAT_RUN = 0;
    localparam int STAT_EOF = 1;

    localparam logic [31:0] LEN_DEFAULT = 32'd240 * 32'd320;

    function automatic logic [31:0] tim_default(input int idx);
        case (idx)
            0:       return 32'd12;
            1:       return 32'd18;
            2:       return 32'd8;
            3:       return 32'd20;
            4:       return 32'd240;
            5:       return 32'd320;
            6:       return 32'd2;
            7:       return 32'd7;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/dispcfg_ctrl.sv
module dispcfg_ctrl
    import dispcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_stat,
    input  logic [7:0]        wdata,
    input  logic              frame_end,
    output logic [7:0]        cmd_o,
    output logic [1:0]        stat_o,
    output logic              run_o,
    output logic              irq_en_o,
    output logic [2:0]        pwr_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             eof;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cmd) begin
            st_d.cmd           = wdata[CMD_W-1:0];
            st_d.cmd[CMD_STOP] = 1'b0;
            if (wdata[CMD_STOP]) begin
                st_d.cmd[CMD_START] = 1'b0;
            end
        end
        if (wr_stat && wdata[STAT_EOF]) begin
            st_d.eof = 1'b0;
        end
        if (frame_end) begin
            st_d.eof = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o    = {{(8-CMD_W){1'b0}}, st_q.cmd};
    assign run_o    = st_q.cmd[CMD_START];
    assign irq_en_o = st_q.cmd[CMD_IRQEN];
    assign stat_o   = {st_q.eof, st_q.cmd[CMD_START]};
    assign pwr_o    = {st_q.cmd[CMD_PANEL], st_q.cmd[CMD_BLIGHT], st_q.cmd[CMD_STEPUP]};
    assign irq_o    = st_q.eof & st_q.cmd[CMD_IRQEN];

endmodule

// File: rtl/dispcfg_bufptr.sv
module dispcfg_bufptr
    import dispcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_len,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] base_o
);

    localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(LEN_DEFAULT);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.base = st_q.addr;
        end
        if (wr_addr) begin
            st_d.addr = wdata[ADDR_W-1:0];
        end
        if (wr_len) begin
            st_d.len = wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.len  <= LEN_RST;
            st_q.base <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign len_o  = st_q.len;
    assign base_o = st_q.base;

endmodule

// File: rtl/dispcfg_timing.sv
module dispcfg_timing
    import dispcfg_pkg::*;
#(
    parameter int TIM_W = 16,
    parameter int NUM   = NUM_TIM
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NUM)-1:0]    wr_idx,
    input  logic [TIM_W-1:0]          wdata,
    output logic [NUM-1:0][TIM_W-1:0] tim_o
);

    localparam int IDX_W = $clog2(NUM);

    for (genvar gi = 0; gi < NUM; gi++) begin : g_reg
        localparam logic [31:0]      DEF32 = tim_default(gi);
        localparam logic [TIM_W-1:0] DEF   = DEF32[TIM_W-1:0];

        logic [TIM_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == IDX_W'(gi))) begin
                val_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= DEF;
            end else begin
                val_q <= val_d;
            end
        end

        assign tim_o[gi] = val_q;
    end

endmodule

// File: rtl/dispcfg_regs.sv
module dispcfg_regs
    import dispcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32,
    parameter int TIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_chipselect,
    input  logic              s_read,
    input  logic              s_write,
    input  logic [3:0]        s_address,
    input  logic [DATA_W-1:0] s_writedata,
    output logic [DATA_W-1:0] s_readdata,
    output logic              s_readdatavalid,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic              irq,
    output logic              ctl_run,
    output logic              pwr_stepup,
    output logic              pwr_backlight,
    output logic              pwr_panel,
    output logic [ADDR_W-1:0] dma_base,
    output logic [LEN_W-1:0]  dma_len,
    output logic [TIM_W-1:0]  t_hbp,
    output logic [TIM_W-1:0]  t_hfp,
    output logic [TIM_W-1:0]  t_vbp,
    output logic [TIM_W-1:0]  t_vfp,
    output logic [TIM_W-1:0]  t_hdata,
    output logic [TIM_W-1:0]  t_vdata,
    output logic [TIM_W-1:0]  t_hsync,
    output logic [TIM_W-1:0]  t_vsync
);

    localparam int IDX_W = $clog2(NUM_TIM);

    logic                          wr_acc, rd_acc, tim_hit;
    logic [OFS_W-1:0]              tim_rel;
    logic [7:0]                    cmd_rb;
    logic [1:0]                    stat_rb;
    logic [2:0]                    pwr_w;
    logic                          irq_en_w;
    logic [ADDR_W-1:0]             addr_rb;
    logic [NUM_TIM-1:0][TIM_W-1:0] tim_w;

    assign wr_acc  = s_chipselect & s_write;
    assign rd_acc  = s_chipselect & s_read;
    assign tim_hit = (s_address >= OFS_TIM0) && (s_address < OFS_TIMEND);
    assign tim_rel = s_address - OFS_TIM0;

    dispcfg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_acc && (s_address == OFS_CMD)),
        .wr_stat   (wr_acc && (s_address == OFS_STAT)),
        .wdata     (s_writedata[7:0]),
        .frame_end (frame_end),
        .cmd_o     (cmd_rb),
        .stat_o    (stat_rb),
        .run_o     (ctl_run),
        .irq_en_o  (irq_en_w),
        .pwr_o     (pwr_w),
        .irq_o     (irq)
    );

    dispcfg_bufptr #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_addr     (wr_acc && (s_address == OFS_FBADDR)),
        .wr_len      (wr_acc && (s_address == OFS_FBLEN)),
        .wdata       (s_writedata),
        .frame_start (frame_start),
        .addr_o      (addr_rb),
        .len_o       (dma_len),
        .base_o      (dma_base)
    );

    dispcfg_timing #(
        .TIM_W (TIM_W),
        .NUM   (NUM_TIM)
    ) u_tim (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_acc && tim_hit),
        .wr_idx (tim_rel[IDX_W-1:0]),
        .wdata  (s_writedata[TIM_W-1:0]),
        .tim_o  (tim_w)
    );

    assign pwr_stepup    = pwr_w[0];
    assign pwr_backlight = pwr_w[1];
    assign pwr_panel     = pwr_w[2];

    assign t_hbp   = tim_w[0];
    assign t_hfp   = tim_w[1];
    assign t_vbp   = tim_w[2];
    assign t_vfp   = tim_w[3];
    assign t_hdata = tim_w[4];
    assign t_vdata = tim_w[5];
    assign t_hsync = tim_w[6];
    assign t_vsync = tim_w[7];

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = '0;
        rd_d.valid = rd_acc;
        if (rd_acc) begin
            if (tim_hit) begin
                rd_d.data[TIM_W-1:0] = tim_w[tim_rel[IDX_W-1:0]];
            end else begin
                case (s_address)
                    OFS_FBADDR: rd_d.data[ADDR_W-1:0] = addr_rb;
                    OFS_FBLEN:  rd_d.data[LEN_W-1:0]  = dma_len;
                    OFS_CMD:    rd_d.data[7:0]        = cmd_rb;
                    OFS_STAT:   rd_d.data[1:0]        = stat_rb;
                    default:    rd_d.data             = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign s_readdata      = rd_q.data;
    assign s_readdatavalid = rd_q.valid;

endmodule

module dispcfg_regs_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_chipselect,
    input logic              s_read,
    input logic              s_write,
    input logic [3:0]        s_address,
    input logic [DATA_W-1:0] s_writedata,
    input logic              s_readdatavalid,
    input logic              frame_start,
    input logic              frame_end,
    input logic              irq,
    input logic              irq_en_w,
    input logic              ctl_run,
    input logic              pwr_stepup,
    input logic [ADDR_W-1:0] dma_base
);

    logic wr_cmd, wr_stat;
    assign wr_cmd  = s_chipselect && s_write && (s_address == 4'h2);
    assign wr_stat = s_chipselect && s_write && (s_address == 4'h3);

    // R2: data valid follows a read request by one cycle
    a_r2_rvalid_on: assert property (@(posedge clk) disable iff (!rst_n)
        (s_chipselect && s_read) |=> s_readdatavalid);
    a_r2_rvalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_chipselect && s_read) |=> !s_readdatavalid);

    // R5: stop forces the run output low
    a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && s_writedata[1]) |=> !ctl_run);

    // R6: step-up pin follows the written command bit
    a_r6_stepup_pin: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> (pwr_stepup == $past(s_writedata[3])));

    // R8: enabled frame end raises the interrupt
    a_r8_eof_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && irq_en_w && !wr_cmd) |=> irq);

    // R8: clearing the flag without a new frame end drops the interrupt
    a_r8_w1c_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && s_writedata[1] && !frame_end) |=> !irq);

    // R9: the latched base changes only after a frame start
    a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(dma_base));

endmodule

bind dispcfg_regs dispcfg_regs_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .s_chipselect    (s_chipselect),
    .s_read          (s_read),
    .s_write         (s_write),
    .s_address       (s_address),
    .s_writedata     (s_writedata),
    .s_readdatavalid (s_readdatavalid),
    .frame_start     (frame_start),
    .frame_end       (frame_end),
    .irq             (irq),
    .irq_en_w        (irq_en_w),
    .ctl_run         (ctl_run),
    .pwr_stepup      (pwr_stepup),
    .dma_base        (dma_base)
);

// File: tb/dispcfg_regs_tb.sv
module dispcfg_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_chipselect = 1'b0, s_read = 1'b0, s_write = 1'b0;
    logic [3:0]  s_address = '0;
    logic [31:0] s_writedata = '0;
    logic [31:0] s_readdata;
    logic        s_readdatavalid;
    logic        frame_start = 1'b0, frame_end = 1'b0;
    logic        irq, ctl_run, pwr_stepup, pwr_backlight, pwr_panel;
    logic [31:0] dma_base, dma_len;
    logic [15:0] t_hbp, t_hfp, t_vbp, t_vfp, t_hdata, t_vdata, t_hsync, t_vsync;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dispcfg_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_chipselect(s_chipselect), .s_read(s_read), .s_write(s_write),
        .s_address(s_address), .s_writedata(s_writedata),
        .s_readdata(s_readdata), .s_readdatavalid(s_readdatavalid),
        .frame_start(frame_start), .frame_end(frame_end),
        .irq(irq), .ctl_run(ctl_run),
        .pwr_stepup(pwr_stepup), .pwr_backlight(pwr_backlight), .pwr_panel(pwr_panel),
        .dma_base(dma_base), .dma_len(dma_len),
        .t_hbp(t_hbp), .t_hfp(t_hfp), .t_vbp(t_vbp), .t_vfp(t_vfp),
        .t_hdata(t_hdata), .t_vdata(t_vdata), .t_hsync(t_hsync), .t_vsync(t_vsync)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compares returned read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && s_readdatavalid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected read data", s_readdata, 32'hxxxx_xxxx);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                chk(t, s_readdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_chipselect = 1'b1; s_write = 1'b1; s_address = a; s_writedata = d;
        @(negedge clk);
        s_chipselect = 1'b0; s_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        s_chipselect = 1'b1; s_read = 1'b1; s_address = a;
        @(negedge clk);
        s_chipselect = 1'b0; s_read = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of outputs and registers
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 run", {31'b0, ctl_run}, 0);
        chk("R1 pwr", {29'b0, pwr_panel, pwr_backlight, pwr_stepup}, 0);
        chk("R1 dma_base", dma_base, 0);
        chk("R1 t_vdata", {16'b0, t_vdata}, 320);
        rd(4'h0, 0, "R1 fbaddr");
        rd(4'h1, 76800, "R1 fblen");
        rd(4'h2, 0, "R1 cmd");
        rd(4'h3, 0, "R1 stat");
        rd(4'h4, 12, "R1 hbp");
        rd(4'h5, 18, "R1 hfp");
        rd(4'h6, 8, "R1 vbp");
        rd(4'h7, 20, "R1 vfp");
        rd(4'h8, 240, "R1 hdata");
        rd(4'h9, 320, "R1 vdata");
        rd(4'hA, 2, "R1 hsync");
        rd(4'hB, 7, "R1 vsync");
        rd(4'hC, 0, "R2 unmapped 0xC");
        rd(4'hF, 0, "R2 unmapped 0xF");

        // R3: 16-bit timing registers
        wr(4'h4, 32'hABCD_1234);
        chk("R3 t_hbp", {16'b0, t_hbp}, 32'h1234);
        rd(4'h4, 32'h1234, "R3 hbp readback");
        wr(4'hB, 32'h0000_0003);
        chk("R3 t_vsync", {16'b0, t_vsync}, 3);
        chk("R3 t_hsync untouched", {16'b0, t_hsync}, 2);

        // R9: base latched only at frame start
        wr(4'h0, 32'h1000_0000);
        chk("R9 base before start", dma_base, 0);
        rd(4'h0, 32'h1000_0000, "R9 addr readback");
        pulse_start();
        chk("R9 base after start", dma_base, 32'h1000_0000);
        wr(4'h0, 32'h2000_0000);
        chk("R9 base mid-frame", dma_base, 32'h1000_0000);
        @(negedge clk);
        frame_start = 1'b1; s_chipselect = 1'b1; s_write = 1'b1;
        s_address = 4'h0; s_writedata = 32'h3000_0000;
        @(negedge clk);
        frame_start = 1'b0; s_chipselect = 1'b0; s_write = 1'b0;
        chk("R9 base same-cycle write", dma_base, 32'h2000_0000);
        pulse_start();
        chk("R9 base next frame", dma_base, 32'h3000_0000);

        // R4: start bit
        wr(4'h2, 32'h01);
        chk("R4 run", {31'b0, ctl_run}, 1);
        rd(4'h3, 1, "R4 status run");
        rd(4'h2, 1, "R4 cmd readback");

        // R6: power pins
        wr(4'h2, 32'h39);
        chk("R6 pwr all", {29'b0, pwr_panel, pwr_backlight, pwr_stepup}, 3'b111);
        wr(4'h2, 32'h11);
        chk("R6 pwr backlight only", {29'b0, pwr_panel, pwr_backlight, pwr_stepup}, 3'b010);

        // R7, R8: end-of-frame flag and interrupt
        wr(4'h2, 32'h01);
        pulse_end();
        chk("R8 irq masked", {31'b0, irq}, 0);
        rd(4'h3, 3, "R7 eof sticky");
        wr(4'h2, 32'h05);
        chk("R8 irq on enable", {31'b0, irq}, 1);
        wr(4'h3, 32'h2);
        chk("R8 irq after clear", {31'b0, irq}, 0);
        rd(4'h3, 1, "R8 status after clear");
        pulse_end();
        chk("R8 irq on frame end", {31'b0, irq}, 1);
        @(negedge clk);
        frame_end = 1'b1; s_chipselect = 1'b1; s_write = 1'b1;
        s_address = 4'h3; s_writedata = 32'h2;
        @(negedge clk);
        frame_end = 1'b0; s_chipselect = 1'b0; s_write = 1'b0;
        chk("R8 set wins over clear", {31'b0, irq}, 1);

        // R10: ignored writes
        wr(4'h3, 32'h0);
        chk("R10 run kept", {31'b0, ctl_run}, 1);
        rd(4'h3, 3, "R10 status kept");
        wr(4'hD, 32'hFFFF_FFFF);
        rd(4'hD, 0, "R10 unmapped read");
        rd(4'h0, 32'h3000_0000, "R10 addr kept");
        rd(4'h1, 76800, "R10 len kept");
        rd(4'h2, 32'h05, "R10 cmd kept");
        rd(4'hB, 3, "R10 vsync kept");
        chk("R10 pwr kept", {29'b0, pwr_panel, pwr_backlight, pwr_stepup}, 0);

        // R5: stop
        wr(4'h2, 32'h02);
        chk("R5 stop run", {31'b0, ctl_run}, 0);
        rd(4'h2, 0, "R5 cmd after stop");
        wr(4'h2, 32'h07);
        chk("R5 stop wins", {31'b0, ctl_run}, 0);
        rd(4'h2, 32'h04, "R5 cmd start+stop");
        rd(4'h3, 2, "R5 status run low");
        wr(4'h2, 32'hFF);
        rd(4'h2, 32'h3C, "R2 R5 cmd upper bits");
        chk("R6 pwr from 0xFF", {29'b0, pwr_panel, pwr_backlight, pwr_stepup}, 3'b111);

        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule